// File: doc/BRIEF.md
# Multi-Channel Edge-Programmed PWM Generator

This block drives sixteen pulse-width outputs from a single shared timebase. A prescaler divides the input clock, and a step counter counts prescaled steps across one period. The prescale and period settings apply to every channel. Each channel does not hold a duty count. Instead it holds two step positions: the step at which its output rises and the step at which it falls. The pulse can therefore sit anywhere in the period, can wrap across the period end, or can toggle once per period when both positions are equal.

Software reaches the block through a simple synchronous register bus. Writes take effect on the clock edge, and reads are combinational. Every channel has a shadow pair of edge registers and a live pair. In immediate mode a write to the shadow pair updates the live pair on the same edge. In synchronized mode the live pair takes the shadow values only on the edge where the step counter wraps to zero. A multi-register change can therefore never take effect part-way through a period. Enables are grouped eight channels to a register. Toggling an enable never disturbs the timebase.

Top module: `pwm_edge_gen`

## Requirements
- R1: After reset every register reads 0 and every output is low.
- R2: The address is split into fields. Bits [6:5] select the region: 0 is control, 1 is the writable shadow edges, and 2 is the read-only live edges. In the edge regions, bits [4:1] give the channel and bit 0 selects rise (0) or fall (1). In the control region, address 0 holds the sync-mode flag in bit 0, address 1 the prescale value and address 2 the period value. Read data is combinational.
- R3: One output period lasts (prescale+1)×(period+1) clocks. The prescaler counts 0..prescale, and the step counter advances on each prescaler terminal count, counting 0..period before it wraps to 0.
- R4: When rise < fall, a channel is high for steps rise ≤ s < fall. Each output reflects the step counter with a latency of one clock.
- R5: When fall < rise, a channel is high for steps s ≥ rise or s < fall, so the pulse wraps through the period end.
- R6: When rise equals fall, the output toggles once per period at that step, so its period is twice the programmed period.
- R7: An edge value above the period value is never reached. If rise is beyond the period the channel never goes high, and if fall is beyond the period the channel never goes low after it rises.
- R8: Enables sit in control address 3 (channels 0–7) and control address 4 (channels 8–15), with the bit index equal to the channel number mod 8. A disabled channel is driven low, starting no later than the second clock edge after the write.
- R9: Writing an enable register never resets or shifts the shared timebase.
- R10: With the sync flag at 0, a shadow-edge write also updates the live value on the same edge.
- R11: With the sync flag at 1, the live edge values change only on the edge where the step counter wraps to 0. On that edge they are loaded from the shadow values.
- R12: Writes to the live region are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 7 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pwm_out | output | 16 | Channel outputs |

## Verification
On every cycle, the assertions check the mechanics of the timebase and the rules for updating the live registers:

- the prescaler and step counter wrap where they should, and the step counter holds between terminal counts;
- in synchronized mode the live edges stay frozen between boundaries and take exactly the prior shadow values at a wrap;
- a disabled channel is low.

Only the bench scenarios can show that the waveforms have the right shape for ordered, wrapped, equal and out-of-range edge pairs, measured against a step model. The same applies to the exact length of the period for two timebase settings, the mapping of enable bits across the two banks, and the fact that an enable change leaves the period marker in place.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int BANK_W         = 8;
    localparam int CTRL_SYNC      = 0;
    localparam int CTRL_PRESCALE  = 1;
    localparam int CTRL_PERIOD    = 2;
    localparam int CTRL_EN_BASE   = 3;

    typedef enum logic [1:0] {
        RGN_CTRL   = 2'd0,
        RGN_SHADOW = 2'd1,
        RGN_LIVE   = 2'd2,
        RGN_NONE   = 2'd3
    } region_e;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] prescale,
    input  logic [W-1:0] period,
    output logic [W-1:0] step,
    output logic         step_entry,
    output logic         wrap
);
    typedef struct packed {
        logic [W-1:0] pre;
        logic [W-1:0] step;
    } tb_state_t;

    tb_state_t state_d, state_q;
    logic      tick;

    always_comb begin
        state_d = state_q;
        tick    = (state_q.pre >= prescale);
        wrap    = tick && (state_q.step >= period);
        state_d.pre = tick ? '0 : state_q.pre + 1'b1;
        if (tick) begin
            state_d.step = wrap ? '0 : state_q.step + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign step       = state_q.step;
    assign step_entry = (state_q.pre == '0);

    AST_PRE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.pre >= prescale) |=> (state_q.pre == '0)); // R3
    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap) |=> (state_q.step == '0)); // R3
    AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.pre < prescale) |=> $stable(state_q.step)); // R3
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int W      = 8,
    localparam int CH_W  = $clog2(NCH),
    localparam int ADDR_W = CH_W + 3,
    localparam int NBANK = NCH / BANK_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic [W-1:0]            bus_wdata,
    output logic [W-1:0]            bus_rdata,
    input  logic                    commit,
    output logic [W-1:0]            prescale,
    output logic [W-1:0]            period,
    output logic [NCH-1:0]          chan_en,
    output logic [NCH-1:0][W-1:0]   rise_live,
    output logic [NCH-1:0][W-1:0]   fall_live
);
    typedef struct packed {
        logic                  sync;
        logic [W-1:0]          prescale;
        logic [W-1:0]          period;
        logic [NCH-1:0]        en;
        logic [NCH-1:0][W-1:0] rise_sh;
        logic [NCH-1:0][W-1:0] fall_sh;
        logic [NCH-1:0][W-1:0] rise_lv;
        logic [NCH-1:0][W-1:0] fall_lv;
    } reg_state_t;

    reg_state_t regs_d, regs_q;

    region_e         rgn;
    logic [CH_W-1:0] ch;
    logic            sel_fall;
    logic [CH_W:0]   ctrl_idx;

    assign rgn      = region_e'(bus_addr[ADDR_W-1 -: 2]);
    assign ch       = bus_addr[CH_W:1];
    assign sel_fall = bus_addr[0];
    assign ctrl_idx = bus_addr[CH_W:0];

    always_comb begin
        regs_d = regs_q;
        // boundary transfer of the shadow pairs, synchronized mode only
        if (regs_q.sync && commit) begin
            regs_d.rise_lv = regs_q.rise_sh;
            regs_d.fall_lv = regs_q.fall_sh;
        end
        if (bus_wr) begin
            unique case (rgn)
                RGN_CTRL: begin
                    if (int'(ctrl_idx) == CTRL_SYNC)     regs_d.sync     = bus_wdata[0];
                    if (int'(ctrl_idx) == CTRL_PRESCALE) regs_d.prescale = bus_wdata;
                    if (int'(ctrl_idx) == CTRL_PERIOD)   regs_d.period   = bus_wdata;
                    for (int k = 0; k < NBANK; k++) begin
                        if (int'(ctrl_idx) == CTRL_EN_BASE + k)
                            regs_d.en[k*BANK_W +: BANK_W] = bus_wdata[BANK_W-1:0];
                    end
                end
                RGN_SHADOW: begin
                    if (sel_fall) begin
                        regs_d.fall_sh[ch] = bus_wdata;
                        if (!regs_q.sync) regs_d.fall_lv[ch] = bus_wdata;
                    end else begin
                        regs_d.rise_sh[ch] = bus_wdata;
                        if (!regs_q.sync) regs_d.rise_lv[ch] = bus_wdata;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (rgn)
            RGN_CTRL: begin
                if (int'(ctrl_idx) == CTRL_SYNC)     bus_rdata[0] = regs_q.sync;
                if (int'(ctrl_idx) == CTRL_PRESCALE) bus_rdata    = regs_q.prescale;
                if (int'(ctrl_idx) == CTRL_PERIOD)   bus_rdata    = regs_q.period;
                for (int k = 0; k < NBANK; k++) begin
                    if (int'(ctrl_idx) == CTRL_EN_BASE + k)
                        bus_rdata[BANK_W-1:0] = regs_q.en[k*BANK_W +: BANK_W];
                end
            end
            RGN_SHADOW: bus_rdata = sel_fall ? regs_q.fall_sh[ch] : regs_q.rise_sh[ch];
            RGN_LIVE:   bus_rdata = sel_fall ? regs_q.fall_lv[ch] : regs_q.rise_lv[ch];
            default:    bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign prescale  = regs_q.prescale;
    assign period    = regs_q.period;
    assign chan_en   = regs_q.en;
    assign rise_live = regs_q.rise_lv;
    assign fall_live = regs_q.fall_lv;

    AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.sync && !commit) |=> ($stable(regs_q.rise_lv) && $stable(regs_q.fall_lv))); // R11
    AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.sync && commit) |=> (regs_q.rise_lv == $past(regs_q.rise_sh)
                                     && regs_q.fall_lv == $past(regs_q.fall_sh))); // R11
    AST_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!regs_q.sync && bus_wr && rgn == RGN_SHADOW && !sel_fall)
            |=> (regs_q.rise_lv[$past(ch)] == $past(bus_wdata))); // R10
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] step,
    input  logic         step_entry,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] fall,
    input  logic         enable,
    output logic         wave
);
    typedef struct packed {
        logic tog;
        logic out;
    } ch_state_t;

    ch_state_t ch_d, ch_q;
    logic      level;

    always_comb begin
        ch_d = ch_q;
        if (step_entry && (step == rise) && (rise == fall)) begin
            ch_d.tog = ~ch_q.tog;
        end
        if (rise < fall)      level = (step >= rise) && (step < fall);
        else if (fall < rise) level = (step >= rise) || (step < fall);
        else                  level = ch_d.tog;
        ch_d.out = enable & level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign wave = ch_q.out;

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable) |=> (!wave)); // R8
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen #(
    parameter int NCH     = 16,
    parameter int W       = 8,
    localparam int ADDR_W = $clog2(NCH) + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic [NCH-1:0]    pwm_out
);
    logic [W-1:0]          prescale, period, step;
    logic                  step_entry, wrap;
    logic [NCH-1:0]        chan_en;
    logic [NCH-1:0][W-1:0] rise_live, fall_live;

    pwm_timebase #(.W(W)) u_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .prescale   (prescale),
        .period     (period),
        .step       (step),
        .step_entry (step_entry),
        .wrap       (wrap)
    );

    pwm_regs #(.NCH(NCH), .W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .commit    (wrap),
        .prescale  (prescale),
        .period    (period),
        .chan_en   (chan_en),
        .rise_live (rise_live),
        .fall_live (fall_live)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwm_channel #(.W(W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .step       (step),
            .step_entry (step_entry),
            .rise       (rise_live[c]),
            .fall       (fall_live[c]),
            .enable     (chan_en[c]),
            .wave       (pwm_out[c])
        );
    end
endmodule

// File: tb/pwm_edge_gen_test.sv
module pwm_edge_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] pwm_out;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int mark = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwm_edge_gen uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    // rows: channel, rise, fall
    localparam int NV = 6;
    localparam int VEC [0:NV-1][0:2] = '{
        '{1, 2, 5}, '{2, 7, 3}, '{3, 0, 12}, '{4, 12, 14}, '{5, 9, 0}, '{9, 3, 6}
    };

    function automatic logic [6:0] ea(input int rgn, input int ch, input int sel);
        return 7'((rgn << 5) | (ch << 1) | sel);
    endfunction

    function automatic logic exp_lvl(input int r, input int f, input int s);
        if (r < f) return (s >= r) && (s < f);
        return (s >= r) || (s < f);
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic wait_marker();
        logic p;
        p = pwm_out[0];
        forever begin
            @(negedge clk);
            if (pwm_out[0] && !p) break;
            p = pwm_out[0];
        end
        mark = cyc;
    endtask

    task automatic go_to(input int k);
        while (cyc - mark < k) @(negedge clk);
    endtask

    task automatic period_scan(input int ch, input int r, input int f, input string tag);
        int bad;
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            go_to(k);
            if (pwm_out[ch] !== exp_lvl(r, f, k / 2)) bad++;
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v, m0, v1, v2;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(pwm_out == 16'h0, "R1 outputs low", int'(pwm_out), 0);
        rd(ea(0, 0, 1), v); chk(v == 0, "R1 prescale reset", v, 0);
        rd(ea(0, 1, 0), v); chk(v == 0, "R1 period reset", v, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R3: timebase registers and readback
        wr(ea(0, 0, 1), 8'd1);
        wr(ea(0, 1, 0), 8'd9);
        rd(ea(0, 0, 1), v); chk(v == 1, "R2 prescale readback", v, 1);
        rd(ea(0, 1, 0), v); chk(v == 9, "R2 period readback", v, 9);
        wr(ea(0, 1, 1), 8'hFF);
        wr(ea(0, 2, 0), 8'h02);
        rd(ea(0, 2, 0), v); chk(v == 2, "R8 upper enable readback", v, 2);

        // R10: immediate mode, marker channel 0 high only at step 0
        wr(ea(1, 0, 0), 8'd0);
        wr(ea(1, 0, 1), 8'd1);
        rd(ea(2, 0, 1), v); chk(v == 1, "R10 live follows write", v, 1);

        // R3: period length 2*10 clocks
        wait_marker(); m0 = mark;
        wait_marker();
        chk(mark - m0 == 20, "R3 period length", mark - m0, 20);

        // table walk: R4 R5 R7 R8 shapes
        for (int i = 0; i < NV; i++) begin
            wr(ea(1, VEC[i][0], 0), 8'(VEC[i][1]));
            wr(ea(1, VEC[i][0], 1), 8'(VEC[i][2]));
            wait_marker();
            period_scan(VEC[i][0], VEC[i][1], VEC[i][2], $sformatf("R4/R5/R7/R8 row %0d", i));
        end

        // R8: channel 10 not enabled stays low
        wr(ea(1, 10, 0), 8'd1);
        wr(ea(1, 10, 1), 8'd8);
        wait_marker();
        begin
            int hi;
            hi = 0;
            for (int k = 0; k < 20; k++) begin go_to(k); if (pwm_out[10]) hi++; end
            chk(hi == 0, "R8 disabled channel low", hi, 0);
        end

        // R6: equal edges toggle once per period
        wr(ea(1, 6, 0), 8'd4);
        wr(ea(1, 6, 1), 8'd4);
        wait_marker(); go_to(12); v1 = int'(pwm_out[6]);
        wait_marker(); go_to(12); v2 = int'(pwm_out[6]);
        chk(v1 != v2, "R6 toggle per period", v2, 1 - v1);

        // R8 / R9: disable then re-enable; timebase untouched
        wait_marker(); m0 = mark;
        go_to(5);
        wr(ea(0, 1, 1), 8'hBF);
        @(negedge clk);
        chk(pwm_out[6] == 1'b0, "R8 disable forces low", int'(pwm_out[6]), 0);
        wr(ea(0, 1, 1), 8'hFF);
        wait_marker();
        chk(mark - m0 == 20, "R9 timebase not disturbed", mark - m0, 20);

        // R11: synchronized update of channel 1 from (2,5) to (6,8)
        wr(ea(0, 0, 0), 8'd1);
        rd(ea(0, 0, 0), v); chk(v == 1, "R2 sync flag readback", v, 1);
        wait_marker();
        go_to(2);
        wr(ea(1, 1, 0), 8'd6);
        wr(ea(1, 1, 1), 8'd8);
        rd(ea(2, 1, 0), v); chk(v == 2, "R11 live held before boundary", v, 2);
        rd(ea(1, 1, 0), v); chk(v == 6, "R11 shadow holds new rise", v, 6);
        go_to(9);
        chk(pwm_out[1] == 1'b1, "R11 old waveform kept mid-period", int'(pwm_out[1]), 1);
        go_to(18);
        rd(ea(2, 1, 1), v); chk(v == 5, "R11 live fall held at period end", v, 5);
        wait_marker();
        rd(ea(2, 1, 0), v); chk(v == 6, "R11 live committed at wrap", v, 6);
        period_scan(1, 6, 8, "R11 new waveform after boundary");

        // R12: live region is read-only
        wr(ea(2, 1, 0), 8'h55);
        wait_marker();
        rd(ea(2, 1, 0), v); chk(v == 6, "R12 live write ignored", v, 6);

        // R3: second timebase setting, 1*4 clocks
        wr(ea(0, 0, 1), 8'd0);
        wr(ea(0, 1, 0), 8'd3);
        wait_marker(); m0 = mark;
        wait_marker();
        chk(mark - m0 == 4, "R3 short period length", mark - m0, 4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule